// File: doc/BRIEF.md
# Windowed Watchdog Timer with Lockable Control

This block is a watchdog counter for a processor subsystem. Software programs a control byte to pick one of seven timeout periods and, optionally, a window mode. It then services the timer by writing an arm key followed by a fire key to a service byte. If the count runs out, or if software services it wrongly, the block raises a single-cycle reset request that an external reset generator consumes.

In normal operating mode the configuration fields take only one write after reset, so runaway code cannot weaken the watchdog. In special operating mode the fields stay writable. A mask bit in the control byte lets a debugger change only the sticky debug-stop bit without using up the single write. Two inputs pause the counter. A low-power wait input clears the count and holds it at zero. A debug-active input freezes the count at its current value.

Top module: `wdog_win`

## Requirements
- R1: Control byte layout is rate in bits [2:0], window in bit 3, wait-stop in bit 4, debug-stop in bit 5 and mask in bit 6 (bit 6 and bit 7 always read 0). After reset it reads 0x00 and the reset request is low. Rate 000 disables the timer: no expiry occurs, and service writes have no effect.
- R2: Rate codes 1 to 7 select periods of 2^(E-EXP_SHRINK) clocks, with E equal to 14, 16, 18, 20, 22, 23 and 24. After a restart, the request rises for exactly one cycle P cycles later, and the count then starts again from zero.
- R3: Writing 0x55 to the service byte arms the timer and may be repeated. Writing 0xAA while armed restarts the count from zero.
- R4: With window mode set, a service write while the count is below three quarters of the period raises the request. After a restart, the window closes again until the count reaches three quarters.
- R5: A service value other than 0x55 or 0xAA, or 0xAA while not armed, raises the request.
- R6: In normal mode, window, rate and wait-stop accept only the first unmasked control write after reset. In special mode they accept every unmasked write.
- R7: In normal mode, a first write of rate 000 leaves the rate unchanged but still consumes the single write.
- R8: A control write with bit 6 set leaves window, rate and wait-stop unchanged and does not consume the single write.
- R9: Debug-stop is applied on every control write, masked or not. In special mode it takes the written value. In normal mode it can only be set.
- R10: The count restarts on an accepted unmasked control write with a nonzero rate, and on a 0-to-1 change of debug-stop. A masked write that leaves debug-stop unchanged does not restart it.
- R11: While wait-stop and the wait input are both set, the count is held at zero.
- R12: While debug-stop and the debug-active input are both set, the count holds its value. With debug-stop clear, the debug-active input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| special_mode | input | 1 | High selects unrestricted control writes |
| wait_active | input | 1 | Processor is in low-power wait |
| debug_active | input | 1 | Debugger has halted the processor |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control read data |
| svc_wr | input | 1 | Service byte write strobe |
| svc_wdata | input | 8 | Service write data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A corrupt count or a wrong period decode shows up as a reset request that arrives early or late. The bench measures this to the exact cycle from each restart, so an error of one cycle is caught within one period. A lost arm state or a wrong window threshold shows up as a request on the cycle after the offending service write. A lock flag that fails to set, or a sticky bit that clears, shows up in the control read data right after the next write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int RATE_W    = 3;
   localparam int NUM_CODES = 1 << RATE_W;
   localparam int MAX_LOG2  = 24;

   typedef struct packed {
      logic              dbg_stop;
      logic              wait_stop;
      logic              win;
      logic [RATE_W-1:0] rate;
   } wdog_ctl_t;

   // log2 of the full-scale period for each rate code; 0 for the off code
   function automatic int base_log2(input int code);
      case (code)
         1:       return 14;
         2:       return 16;
         3:       return 18;
         4:       return 20;
         5:       return 22;
         6:       return 23;
         7:       return 24;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/wdog_ctl.sv
module wdog_ctl
   import wdog_pkg::*;
#(
   parameter logic [RATE_W-1:0] RST_RATE = '0,
   parameter logic              RST_WIN  = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      special_mode,
   input  logic      wr,
   input  logic [7:0] wdata,
   output wdog_ctl_t ctl,
   output logic      locked,
   output logic      restart
);
   localparam int B_WIN  = RATE_W;
   localparam int B_WAIT = RATE_W + 1;
   localparam int B_DBG  = RATE_W + 2;
   localparam int B_MASK = RATE_W + 3;

   wdog_ctl_t         ctl_q, ctl_d;
   logic              locked_q, locked_d;
   logic [RATE_W-1:0] wr_rate;
   logic              open_wr;

   assign wr_rate = wdata[RATE_W-1:0];
   assign open_wr = special_mode || !locked_q;

   always_comb begin
      ctl_d    = ctl_q;
      locked_d = locked_q;
      restart  = 1'b0;
      if (wr) begin
         if (!wdata[B_MASK]) begin
            locked_d = 1'b1;
            if (special_mode) begin
               ctl_d.rate      = wr_rate;
               ctl_d.win       = wdata[B_WIN];
               ctl_d.wait_stop = wdata[B_WAIT];
            end else if (!locked_q) begin
               if (wr_rate != '0) ctl_d.rate = wr_rate;
               if (wdata[B_WIN])  ctl_d.win  = 1'b1;
               ctl_d.wait_stop = wdata[B_WAIT];
            end
            if (open_wr && wr_rate != '0) restart = 1'b1;
         end
         if (special_mode)      ctl_d.dbg_stop = wdata[B_DBG];
         else if (wdata[B_DBG]) ctl_d.dbg_stop = 1'b1;
         if (ctl_d.dbg_stop && !ctl_q.dbg_stop) restart = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q    <= '{dbg_stop: 1'b0, wait_stop: 1'b0, win: RST_WIN, rate: RST_RATE};
         locked_q <= 1'b0;
      end else begin
         ctl_q    <= ctl_d;
         locked_q <= locked_d;
      end
   end

   assign ctl    = ctl_q;
   assign locked = locked_q;
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
   import wdog_pkg::*;
#(
   parameter int EXP_SHRINK = 0,
   localparam int CNT_W     = MAX_LOG2 - EXP_SHRINK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   input  logic              clear,
   input  logic              hold_zero,
   input  logic              freeze,
   output logic              expire,
   output logic              in_window,
   output logic [CNT_W-1:0]  cnt
);
   logic [CNT_W-1:0] last_tab [NUM_CODES];
   logic [CNT_W-1:0] open_tab [NUM_CODES];
   logic [CNT_W-1:0] cnt_q;
   logic             enabled, counting;

   for (genvar g = 0; g < NUM_CODES; g++) begin : g_rate
      localparam int LG = (g == 0) ? 2 : base_log2(g) - EXP_SHRINK;
      assign last_tab[g] = CNT_W'((64'd1 << LG) - 64'd1);
      assign open_tab[g] = CNT_W'((64'd1 << LG) - (64'd1 << (LG - 2)));
   end

   assign enabled   = (rate != '0);
   assign counting  = enabled && !hold_zero && !freeze;
   assign expire    = counting && (cnt_q == last_tab[rate]);
   assign in_window = (cnt_q >= open_tab[rate]);

   always_ff @(posedge clk) begin
      if (!rst_n)                                     cnt_q <= '0;
      else if (clear || expire || hold_zero || !enabled) cnt_q <= '0;
      else if (!freeze)                               cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/wdog_key.sv
module wdog_key #(
   parameter logic [7:0] KEY_ARM  = 8'h55,
   parameter logic [7:0] KEY_FIRE = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enabled,
   input  logic       win_mode,
   input  logic       in_window,
   input  logic       flush,
   input  logic       svc_wr,
   input  logic [7:0] svc_wdata,
   output logic       svc_restart,
   output logic       fault
);
   logic armed_q, armed_d, window_ok;

   assign window_ok = !win_mode || in_window;

   always_comb begin
      armed_d     = armed_q;
      svc_restart = 1'b0;
      fault       = 1'b0;
      if (svc_wr && enabled) begin
         if (svc_wdata == KEY_ARM && window_ok) begin
            armed_d = 1'b1;
         end else if (svc_wdata == KEY_FIRE && window_ok && armed_q) begin
            armed_d     = 1'b0;
            svc_restart = 1'b1;
         end else begin
            armed_d = 1'b0;
            fault   = 1'b1;
         end
      end
      if (flush) armed_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= armed_d;
   end
endmodule

// File: rtl/wdog_win.sv
module wdog_win
   import wdog_pkg::*;
#(
   parameter int                EXP_SHRINK = 0,
   parameter logic [RATE_W-1:0] RST_RATE   = '0,
   parameter logic              RST_WIN    = 1'b0,
   parameter logic [7:0]        KEY_ARM    = 8'h55,
   parameter logic [7:0]        KEY_FIRE   = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       special_mode,
   input  logic       wait_active,
   input  logic       debug_active,
   input  logic       ctl_wr,
   input  logic [7:0] ctl_wdata,
   output logic [7:0] ctl_rdata,
   input  logic       svc_wr,
   input  logic [7:0] svc_wdata,
   output logic       rst_req
);
   localparam int CNT_W = MAX_LOG2 - EXP_SHRINK;

   if (EXP_SHRINK < 0 || EXP_SHRINK > MAX_LOG2 - 14 + 2) begin : g_bad_shrink
      $error("EXP_SHRINK must keep every period at least four clocks");
   end
   if (KEY_ARM == KEY_FIRE) begin : g_bad_keys
      $error("arm and fire keys must differ");
   end

   wdog_ctl_t           ctl_w;
   logic                locked_w, ctl_restart, svc_restart, fault, expire, in_window;
   logic                clear_any, hold_zero, freeze, rst_req_q;
   logic [CNT_W-1:0]    cnt_w;
   logic [MAX_LOG2-1:0] cnt_ext;

   assign hold_zero = ctl_w.wait_stop && wait_active;
   assign freeze    = ctl_w.dbg_stop && debug_active;
   assign clear_any = ctl_restart || svc_restart || fault;
   assign cnt_ext   = MAX_LOG2'(cnt_w);

   wdog_ctl #(.RST_RATE(RST_RATE), .RST_WIN(RST_WIN)) u_ctl (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .wr(ctl_wr), .wdata(ctl_wdata),
      .ctl(ctl_w), .locked(locked_w), .restart(ctl_restart)
   );

   wdog_cnt #(.EXP_SHRINK(EXP_SHRINK)) u_cnt (
      .clk(clk), .rst_n(rst_n), .rate(ctl_w.rate), .clear(clear_any),
      .hold_zero(hold_zero), .freeze(freeze),
      .expire(expire), .in_window(in_window), .cnt(cnt_w)
   );

   wdog_key #(.KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_key (
      .clk(clk), .rst_n(rst_n), .enabled(ctl_w.rate != '0),
      .win_mode(ctl_w.win), .in_window(in_window),
      .flush(expire || ctl_restart),
      .svc_wr(svc_wr), .svc_wdata(svc_wdata),
      .svc_restart(svc_restart), .fault(fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rst_req_q <= 1'b0;
      else        rst_req_q <= expire || fault;
   end

   assign rst_req   = rst_req_q;
   assign ctl_rdata = {2'b00, ctl_w.dbg_stop, ctl_w.wait_stop, ctl_w.win, ctl_w.rate};
endmodule

// File: rtl/wdog_win_chk.sv
module wdog_win_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        special_mode,
   input logic        wait_active,
   input logic        debug_active,
   input logic        rst_req,
   input logic [2:0]  rate,
   input logic        win,
   input logic        wait_stop,
   input logic        dbg_stop,
   input logic        locked,
   input logic [23:0] cnt,
   input logic        expire,
   input logic        fault,
   input logic        clear_any
);
   // R1
   off_no_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate == 3'd0) |-> !expire);

   // R2
   req_after_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire || fault) |=> rst_req);

   // R2
   req_only_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(expire || fault) |=> !rst_req);

   // R3
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_any |=> (cnt == 24'd0));

   // R6
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !special_mode) |=> ($stable(rate) && $stable(win) && $stable(wait_stop)));

   // R9
   dbg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_stop && !special_mode) |=> dbg_stop);

   // R11
   wait_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_stop && wait_active) |=> (cnt == 24'd0));

   // R12
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_stop && debug_active && !(wait_stop && wait_active) && !clear_any && rate != 3'd0)
      |=> $stable(cnt));
endmodule

bind wdog_win wdog_win_chk u_chk (
   .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
   .wait_active(wait_active), .debug_active(debug_active), .rst_req(rst_req),
   .rate(ctl_w.rate), .win(ctl_w.win), .wait_stop(ctl_w.wait_stop),
   .dbg_stop(ctl_w.dbg_stop), .locked(locked_w), .cnt(cnt_ext),
   .expire(expire), .fault(fault), .clear_any(clear_any)
);

// File: tb/wdog_win_tb.sv
module wdog_win_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SHRINK     = 10;
   localparam int P1         = 16;
   localparam int P3         = 256;

   logic       clk = 1'b0;
   logic       rst_n, special_mode, wait_active, debug_active;
   logic       ctl_wr, svc_wr, rst_req;
   logic [7:0] ctl_wdata, ctl_rdata, svc_wdata;
   int         checks = 0;
   int         errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wdog_win #(.EXP_SHRINK(SHRINK)) u_dut (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .wait_active(wait_active), .debug_active(debug_active),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .svc_wr(svc_wr), .svc_wdata(svc_wdata), .rst_req(rst_req)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic sp);
      rst_n = 1'b0; special_mode = sp; wait_active = 1'b0; debug_active = 1'b0;
      ctl_wr = 1'b0; ctl_wdata = '0; svc_wr = 1'b0; svc_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic ctl_write(input logic [7:0] d);
      ctl_wdata = d; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic svc_write(input logic [7:0] d);
      svc_wdata = d; svc_wr = 1'b1;
      @(negedge clk);
      svc_wr = 1'b0;
   endtask

   task automatic quiet(input int n, output int hits);
      hits = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rst_req) hits++;
      end
   endtask

   // cycles from now until the request is seen, then checks it lasts one cycle
   task automatic measure(input string req, input int exp);
      int n = 0;
      while (n < 2 * exp + 20) begin
         @(negedge clk);
         n++;
         if (rst_req) break;
      end
      chk(req, n, exp);
      @(negedge clk);
      chk({req, " pulse width"}, int'(rst_req), 0);
   endtask

   task automatic t_reset_and_off();
      int h;
      do_reset(1'b0);
      chk("R1 reset rdata", int'(ctl_rdata), 0);
      chk("R1 reset req", int'(rst_req), 0);
      quiet(300, h);
      chk("R1 off no expiry", h, 0);
      svc_write(8'h12);
      quiet(2, h);
      chk("R1 off service ignored", h, 0);
   endtask

   task automatic t_periods();
      do_reset(1'b1);
      ctl_write(8'h01);
      measure("R2 period code1", P1);
      measure("R2 repeat after expiry", P1 - 1);
      ctl_write(8'h03);
      measure("R2 period code3", P3);
   endtask

   task automatic t_service();
      do_reset(1'b0);
      ctl_write(8'h01);
      repeat (3) @(negedge clk);
      svc_write(8'h55);
      svc_write(8'h55);
      svc_write(8'hAA);
      measure("R3 restart by key pair", P1);
      do_reset(1'b0);
      ctl_write(8'h09);
      repeat (12) @(negedge clk);
      svc_write(8'h55);
      svc_write(8'h55);
      svc_write(8'hAA);
      measure("R3 R4 restart inside window", P1);
   endtask

   task automatic t_window_early();
      do_reset(1'b0);
      ctl_write(8'h09);
      repeat (11) @(negedge clk);
      svc_write(8'h55);
      chk("R4 early service", int'(rst_req), 1);
      do_reset(1'b0);
      ctl_write(8'h09);
      repeat (12) @(negedge clk);
      svc_write(8'h55);
      svc_write(8'hAA);
      chk("R4 legal restart", int'(rst_req), 0);
      svc_write(8'h55);
      chk("R4 window closed after restart", int'(rst_req), 1);
   endtask

   task automatic t_bad_key();
      do_reset(1'b0);
      ctl_write(8'h01);
      svc_write(8'h3C);
      chk("R5 illegal value", int'(rst_req), 1);
      do_reset(1'b0);
      ctl_write(8'h01);
      svc_write(8'hAA);
      chk("R5 fire without arm", int'(rst_req), 1);
   endtask

   task automatic t_lock();
      do_reset(1'b0);
      ctl_write(8'h19);
      chk("R6 first write", int'(ctl_rdata), 8'h19);
      ctl_write(8'h03);
      chk("R6 second write ignored", int'(ctl_rdata), 8'h19);
      do_reset(1'b0);
      ctl_write(8'h00);
      chk("R7 zero rate no effect", int'(ctl_rdata), 0);
      ctl_write(8'h0B);
      chk("R7 zero rate used write", int'(ctl_rdata), 0);
      do_reset(1'b1);
      ctl_write(8'h19);
      ctl_write(8'h02);
      chk("R6 special rewrite", int'(ctl_rdata), 8'h02);
   endtask

   task automatic t_mask();
      do_reset(1'b0);
      ctl_write(8'h43);
      chk("R8 masked write", int'(ctl_rdata), 0);
      ctl_write(8'h01);
      chk("R8 write still available", int'(ctl_rdata), 8'h01);
      ctl_write(8'h60);
      chk("R8 R9 masked sets debug-stop", int'(ctl_rdata), 8'h21);
   endtask

   task automatic t_dbg_restart();
      do_reset(1'b0);
      ctl_write(8'h21);
      ctl_write(8'h41);
      chk("R9 normal cannot clear", int'(ctl_rdata), 8'h21);
      do_reset(1'b1);
      ctl_write(8'h21);
      ctl_write(8'h01);
      chk("R9 special clears", int'(ctl_rdata), 8'h01);
      do_reset(1'b0);
      ctl_write(8'h01);
      repeat (8) @(negedge clk);
      ctl_write(8'h60);
      measure("R10 restart on debug-stop rise", P1);
      do_reset(1'b1);
      ctl_write(8'h01);
      repeat (8) @(negedge clk);
      ctl_write(8'h01);
      measure("R10 restart on rate write", P1);
      do_reset(1'b0);
      ctl_write(8'h01);
      repeat (8) @(negedge clk);
      ctl_write(8'h40);
      measure("R10 masked write no restart", P1 - 9);
   endtask

   task automatic t_wait();
      int h;
      do_reset(1'b0);
      ctl_write(8'h11);
      repeat (5) @(negedge clk);
      wait_active = 1'b1;
      quiet(40, h);
      chk("R11 no expiry in wait", h, 0);
      wait_active = 1'b0;
      measure("R11 count from zero", P1);
   endtask

   task automatic t_freeze();
      int h;
      do_reset(1'b0);
      ctl_write(8'h21);
      repeat (5) @(negedge clk);
      debug_active = 1'b1;
      quiet(30, h);
      chk("R12 no expiry frozen", h, 0);
      debug_active = 1'b0;
      measure("R12 resume from held count", P1 - 5);
      do_reset(1'b0);
      ctl_write(8'h01);
      repeat (5) @(negedge clk);
      debug_active = 1'b1;
      measure("R12 no freeze when bit clear", P1 - 5);
      debug_active = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset_and_off();
      t_periods();
      t_service();
      t_window_early();
      t_bad_key();
      t_lock();
      t_mask();
      t_dbg_restart();
      t_wait();
      t_freeze();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule